// File: doc/BRIEF.md
# Interval Timer Channel with Optional Start Interrupt

This block is a single timer channel built around a down counter. In interval mode it produces a periodic interrupt pulse and can toggle a timer output pin on every pulse. In capture mode it latches the running count whenever the capture input rises, and each capture raises the interrupt. Any other mode setting runs the counter silently.

A control bit selects whether counting announces itself. When the bit is set, a start in interval or capture mode raises an interrupt on the start cycle. In interval mode the output also toggles at that moment. When the bit is clear, the first event arrives only after one full period.

Software may write the output level directly. When a software write and a timer toggle fall on the same cycle, the toggle is applied on top of the written level.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `irq`, `timerOut`, `countVal` and `capVal` are all 0.
- R2: A rising `chanEn` loads `reloadVal` into `countVal`. While enabled, the count falls by one per cycle and reloads `reloadVal` on the cycle after it reads 0, so one period is `reloadVal`+1 cycles.
- R3: In interval mode (`modeSel` = 00), each reload gives a one-cycle `irq` pulse. Each such reload toggles `timerOut` when `outEn` = 1.
- R4: With `startIrqEn` = 1 in interval mode, `irq` is 1 in the cycle after the enabling edge. In that same cycle `timerOut` is toggled if `outEn` = 1.
- R5: With `startIrqEn` = 0, the start produces no `irq` and leaves `timerOut` unchanged. The first pulse comes `reloadVal`+1 cycles after the start.
- R6: In capture mode (`modeSel` = 01), a start with `startIrqEn` = 1 raises `irq` without touching `timerOut`. While counting, a rising `capIn` copies the pre-edge `countVal` into `capVal` and raises `irq`. Reloads in this mode raise no `irq`.
- R7: With `modeSel` = 10 or 11, the counter runs but `irq` stays 0 and the timer never changes `timerOut`.
- R8: With `outEn` = 0, `timerOut` changes only through software writes.
- R9: A software write (`swWrEn` = 1) alone sets `timerOut` to `swWrData` on the next cycle. If a timer toggle lands on the same cycle, `timerOut` becomes the inverse of `swWrData`.
- R10: While `chanEn` = 0, `countVal` and `timerOut` hold (apart from software writes). Enabling again repeats the start sequence, including the optional start interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanEn | input | 1 | Channel run level; a rising level starts counting |
| modeSel | input | 2 | 00 interval, 01 capture, 10/11 other |
| startIrqEn | input | 1 | Raise an interrupt at count start |
| outEn | input | 1 | Allow the timer to toggle the output pin |
| reloadVal | input | CNT_W | Load and reload value of the counter |
| capIn | input | 1 | Capture trigger, rising edge active |
| swWrEn | input | 1 | Software write strobe for the output level |
| swWrData | input | 1 | Level written by software |
| irq | output | 1 | One-cycle interrupt pulse |
| timerOut | output | 1 | Timer output pin |
| countVal | output | CNT_W | Current counter value |
| capVal | output | CNT_W | Last captured count |

## Verification
The bench targets the start cycle with the interrupt bit both set and clear. A design that mixed these up would pulse early or toggle the pin on a quiet start.

It also targets a software write that coincides with a timer toggle. A design that lets one side win would leave the pin at the written value or at the old inverse.

A reload value of 0 makes the period a single cycle. Off-by-one reload logic shows up there as a gap in the pulse train.

Captures taken one cycle apart expose a latch that reads the count after its update. Disable and re-enable sequences expose a counter that keeps running or a start interrupt that is not repeated.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_CAPTURE  = 2'b01,
    MODE_OTHER_A  = 2'b10,
    MODE_OTHER_B  = 2'b11
  } tmrMode_e;

  // strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic capLatch;
    logic irqFire;
    logic toggleOut;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic [1:0] modeSel,
  input  logic       startIrqEn,
  input  logic       outEn,
  input  logic       capIn,
  input  logic       cntZero,
  output tmrStrobe_t strobe,
  output logic       running
);

  logic capPrev;
  logic startNow;
  logic counting;
  logic isInterval;
  logic isCapture;
  logic capRise;

  assign startNow   = chanEn && !running;
  assign counting   = chanEn && running;
  assign isInterval = (modeSel == MODE_INTERVAL);
  assign isCapture  = (modeSel == MODE_CAPTURE);
  assign capRise    = capIn && !capPrev;

  always_comb begin
    strobe = '0;
    if (startNow) begin
      strobe.loadCnt   = 1'b1;
      strobe.irqFire   = startIrqEn && (isInterval || isCapture);
      strobe.toggleOut = startIrqEn && isInterval && outEn;
    end else if (counting) begin
      if (cntZero) begin
        strobe.loadCnt = 1'b1;
        if (isInterval) begin
          strobe.irqFire   = 1'b1;
          strobe.toggleOut = outEn;
        end
      end else begin
        strobe.decCnt = 1'b1;
      end
      if (isCapture && capRise) begin
        strobe.capLatch = 1'b1;
        strobe.irqFire  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      running <= chanEn;
      capPrev <= capIn;
    end
  end

  // a disabled output never sees a timer toggle
  assert_no_toggle_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !strobe.toggleOut);

  // capture mode never toggles the pin
  assert_capture_keeps_pin_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_CAPTURE) |-> !strobe.toggleOut);

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             swWrEn,
  input  logic             swWrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] capVal,
  output logic             irq,
  output logic             timerOut,
  output logic             cntZero
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic outBase;
  logic outNext;

  assign cntZero = (countVal == '0);

  // software level first, timer toggle applied on top of it
  always_comb begin
    outBase = swWrEn ? swWrData : timerOut;
    outNext = strobe.toggleOut ? ~outBase : outBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      capVal   <= '0;
      irq      <= 1'b0;
      timerOut <= 1'b0;
    end else begin
      if (strobe.loadCnt)     countVal <= reloadVal;
      else if (strobe.decCnt) countVal <= countVal - CNT_ONE;
      if (strobe.capLatch)    capVal   <= countVal;
      irq      <= strobe.irqFire;
      timerOut <= outNext;
    end
  end

  // a capture records the count seen before the edge
  assert_capture_pre_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capLatch |=> capVal == $past(countVal));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic [1:0]       modeSel,
  input  logic             startIrqEn,
  input  logic             outEn,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             capIn,
  input  logic             swWrEn,
  input  logic             swWrData,
  output logic             irq,
  output logic             timerOut,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] capVal
);

  tmrStrobe_t strobe;
  logic       cntZero;
  logic       running;

  tmr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chanEn     (chanEn),
    .modeSel    (modeSel),
    .startIrqEn (startIrqEn),
    .outEn      (outEn),
    .capIn      (capIn),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .running    (running)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reloadVal (reloadVal),
    .swWrEn    (swWrEn),
    .swWrData  (swWrData),
    .countVal  (countVal),
    .capVal    (capVal),
    .irq       (irq),
    .timerOut  (timerOut),
    .cntZero   (cntZero)
  );

  assert_reload_after_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && running && countVal == '0) |=> countVal == $past(reloadVal));

  assert_quiet_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !running && !startIrqEn) |=> !irq);

  assert_silent_other_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_OTHER_A || modeSel == MODE_OTHER_B) |=> !irq);

  assert_pin_held_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn && !swWrEn) |=> $stable(timerOut));

  assert_sw_write_lands_R9: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && !strobe.toggleOut) |=> timerOut == $past(swWrData));

  assert_frozen_when_stopped_R10: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> $stable(countVal));

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             chanEn = 1'b0;
  logic [1:0]       modeSel = 2'b00;
  logic             startIrqEn = 1'b0;
  logic             outEn = 1'b0;
  logic [CNT_W-1:0] reloadVal = '0;
  logic             capIn = 1'b0;
  logic             swWrEn = 1'b0;
  logic             swWrData = 1'b0;
  logic             irq;
  logic             timerOut;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] capVal;

  int    nChecks = 0;
  int    nErrors = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // expected state, built from the requirements
  logic [CNT_W-1:0] mCnt, mCap;
  logic             mIrq, mOut, mRun, mCapPrev;

  always #2 clk = ~clk;

  tmr_channel #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .modeSel(modeSel),
    .startIrqEn(startIrqEn), .outEn(outEn), .reloadVal(reloadVal),
    .capIn(capIn), .swWrEn(swWrEn), .swWrData(swWrData),
    .irq(irq), .timerOut(timerOut), .countVal(countVal), .capVal(capVal)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = '0; mCap = '0; mIrq = 1'b0; mOut = 1'b0; mRun = 1'b0; mCapPrev = 1'b0;
    end else begin
      logic [CNT_W-1:0] oldCnt;
      logic irqN, tog, o;
      oldCnt = mCnt;
      irqN = 1'b0;
      tog  = 1'b0;
      if (chanEn && !mRun) begin
        mCnt = reloadVal;
        if (startIrqEn && (modeSel == 2'b00 || modeSel == 2'b01)) irqN = 1'b1;
        if (startIrqEn && modeSel == 2'b00) tog = 1'b1;
      end else if (chanEn && mRun) begin
        if (oldCnt == '0) begin
          mCnt = reloadVal;
          if (modeSel == 2'b00) begin irqN = 1'b1; tog = 1'b1; end
        end else begin
          mCnt = oldCnt - 1'b1;
        end
        if (modeSel == 2'b01 && capIn && !mCapPrev) begin
          mCap = oldCnt;
          irqN = 1'b1;
        end
      end
      o = swWrEn ? swWrData : mOut;
      if (tog && outEn) o = ~o;
      mOut = o;
      mIrq = irqN;
      mRun = chanEn;
      mCapPrev = capIn;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(curReq, "irq", irq, mIrq);
    check(curReq, "timerOut", timerOut, mOut);
    check(curReq, "countVal", countVal, mCnt);
    check(curReq, "capVal", capVal, mCap);
    swWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int irqCount;
    logic [CNT_W-1:0] seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1", "irq at reset", irq, 0);
    check("R1", "timerOut at reset", timerOut, 0);
    check("R1", "countVal at reset", countVal, 0);
    check("R1", "capVal at reset", capVal, 0);
    rstN = 1'b1;
    tick();

    // R4: start interrupt with toggle in interval mode
    curReq = "R4";
    modeSel = 2'b00; startIrqEn = 1'b1; outEn = 1'b1; reloadVal = 16'd3;
    chanEn = 1'b1;
    tick();
    check("R4", "start irq", irq, 1);
    check("R4", "start toggle", timerOut, 1);
    check("R2", "loaded count", countVal, 3);
    // R3: periodic pulses every 4 cycles
    curReq = "R3";
    irqCount = 0;
    for (int i = 0; i < 12; i++) begin tick(); irqCount += irq; end
    check("R3", "pulses in 12 cycles", irqCount, 3);

    // R10: stop holds, re-enable reruns start
    curReq = "R10";
    chanEn = 1'b0;
    tick();
    seen = countVal;
    ticks(5);
    check("R10", "count held", countVal, seen);
    chanEn = 1'b1;
    tick();
    check("R10", "restart irq", irq, 1);

    // R5: quiet start, first pulse after reload+1 cycles
    curReq = "R5";
    chanEn = 1'b0; tick();
    startIrqEn = 1'b0; reloadVal = 16'd2; seen = timerOut;
    chanEn = 1'b1;
    tick();
    check("R5", "no start irq", irq, 0);
    check("R5", "pin held at start", timerOut, seen);
    ticks(2);
    check("R5", "no early irq", irq, 0);
    tick();
    check("R5", "first irq", irq, 1);

    // R2: reload 0 gives a pulse every cycle
    curReq = "R2";
    chanEn = 1'b0; tick();
    reloadVal = 16'd0; chanEn = 1'b1;
    tick();
    irqCount = 0;
    for (int i = 0; i < 6; i++) begin tick(); irqCount += irq; end
    check("R2", "pulses with reload 0", irqCount, 6);

    // R9: write coinciding with start toggle, then write alone
    curReq = "R9";
    chanEn = 1'b0; tick();
    startIrqEn = 1'b1; outEn = 1'b1; reloadVal = 16'd5;
    swWrEn = 1'b1; swWrData = 1'b1; chanEn = 1'b1;
    tick();
    check("R9", "write plus toggle", timerOut, 0);
    swWrEn = 1'b1; swWrData = 1'b1;
    tick();
    check("R9", "write alone", timerOut, 1);

    // R8: output disabled, timer leaves pin alone
    curReq = "R8";
    outEn = 1'b0; seen = timerOut;
    ticks(14);
    check("R8", "pin untouched", timerOut, seen);

    // R6: capture mode
    curReq = "R6";
    chanEn = 1'b0; tick();
    modeSel = 2'b01; startIrqEn = 1'b1; outEn = 1'b1; reloadVal = 16'd9;
    seen = timerOut; chanEn = 1'b1;
    tick();
    check("R6", "capture start irq", irq, 1);
    check("R6", "capture start no toggle", timerOut, seen);
    ticks(3);
    seen = countVal; capIn = 1'b1;
    tick();
    check("R6", "captured value", capVal, seen);
    check("R6", "capture irq", irq, 1);
    capIn = 1'b0;
    ticks(12);

    // R7: other mode stays silent
    curReq = "R7";
    chanEn = 1'b0; tick();
    modeSel = 2'b10; reloadVal = 16'd1; seen = timerOut; chanEn = 1'b1;
    irqCount = 0;
    for (int i = 0; i < 10; i++) begin tick(); irqCount += irq; end
    check("R7", "irq count", irqCount, 0);
    check("R7", "pin unchanged", timerOut, seen);

    // constrained random against the model (R3 and all others)
    curReq = "R3";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 39) == 0) chanEn = ~chanEn;
      if (!chanEn) begin
        modeSel    = 2'($urandom_range(0, 3));
        reloadVal  = CNT_W'($urandom_range(0, 7));
        startIrqEn = 1'($urandom_range(0, 1));
        outEn      = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 3) == 0) capIn = ~capIn;
      if ($urandom_range(0, 7) == 0) begin
        swWrEn = 1'b1; swWrData = 1'($urandom_range(0, 1));
      end
      tick();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule